// File: doc/BRIEF.md
# Migratory Sharing Detector

This block sits next to a coherence directory and watches the stream of requests that reach it, one per cycle, each carrying a request kind, the requesting processor and a line index. For every line it keeps a small record: the set of processors that have read the line since the last exclusive grant, the last exclusive owner, a count of migratory hand-offs and a count of reverts. A hand-off is counted when a processor that is the only reader of a line asks for exclusive rights, and some other processor was the previous owner. This is the read-then-write pattern in which data moves from one processor to the next.

When a line has shown enough hand-offs, it enters migratory mode. From then on, a plain read to that line leaves the block as a read-exclusive, and it carries a flag. The flag tells the reply path to install the copy in the exclusive-migratory state. This saves the store miss that would otherwise follow the load miss. When an owner sees a foreign request before its first write, it sends a revert for the line. A revert takes the line out of migratory mode and restarts its detection. A line that has been reverted a set number of times is pinned, and it never converts again until reset.

Each line runs a three-state machine. TRACK is the normal state: it counts hand-offs, and it moves to MIGR when the count reaches the detect threshold. MIGR converts reads. On a revert it returns to TRACK, or it moves to PINNED when the revert count reaches the revert threshold. PINNED is final. The decided request leaves the block one cycle after it arrives.

Top module: `mig_detector`

## Requirements
- R1: Reset drives all outputs to zero and puts every line in TRACK with empty reader set, no owner and both counts zero; a line that was pinned before reset converts again once it reaches the detect threshold.
- R2: Each request appears on the grant outputs exactly one cycle later; a cycle without a request gives grant_valid=0 and grant_migr=0; a request that is not converted keeps its kind (0 read, 1 read-exclusive, 2 upgrade, 3 reserved, the reserved kind changing no state) with grant_migr=0.
- R3: A hand-off is counted only for a read-exclusive or upgrade from a processor that is the sole reader since the last exclusive grant and differs from the last owner; a request with two readers, or one from the last owner, does not count.
- R4: After DET_TH counted hand-offs on a line, a read to that line is granted as read-exclusive (kind 1) with grant_migr=1, and the requester becomes the owner.
- R5: Read-exclusive and upgrade requests to a line in MIGR pass with their own kind and grant_migr=0.
- R6: A revert to a line in MIGR returns it to TRACK with its hand-off count cleared, so reads pass unconverted until DET_TH new hand-offs are seen.
- R7: A revert to a line that is in TRACK or PINNED has no effect on the line.
- R8: On the REV_TH-th revert a line moves to PINNED, after which no read to it is converted.
- R9: Lines are independent: a request, hand-off or revert on one line changes no other line.
- R10: When a revert and a read address the same line in one cycle, the revert is applied first and the read is not converted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_kind | input | 2 | Request kind: 0 read, 1 read-exclusive, 2 upgrade, 3 reserved |
| req_proc | input | $clog2(NUM_PROCS) | Requesting processor |
| req_line | input | $clog2(NUM_LINES) | Line index of the request |
| rev_valid | input | 1 | A revert message is present this cycle |
| rev_line | input | $clog2(NUM_LINES) | Line index the revert applies to |
| grant_valid | output | 1 | Decided request is present |
| grant_kind | output | 2 | Request kind after possible conversion |
| grant_migr | output | 1 | Grant is to be installed as exclusive-migratory |

## Verification
The bench checks several hand-off sequences that look migratory but do not qualify: two readers before the write, and a write from the processor that already owned the line. A design that counted either would convert the next read too early. It sends reverts to a tracking line and to a pinned line. A design that counted those reverts, or that left pinned mode, would show a converted read where none is expected. It puts a revert and a read to the same line in the same cycle, which separates revert-first ordering from request-first ordering. After a line is pinned, the bench resets and runs the detection again. A reset that left a pin or a stale count would then fail to convert the read.

// File: rtl/mig_pkg.sv
package mig_pkg;

    typedef enum logic [1:0] {
        REQ_RD  = 2'd0,
        REQ_RDX = 2'd1,
        REQ_UPG = 2'd2,
        REQ_RSV = 2'd3
    } req_kind_e;

    typedef enum logic [1:0] {
        LS_TRACK  = 2'd0,
        LS_MIGR   = 2'd1,
        LS_PINNED = 2'd2
    } line_state_e;

endpackage

// File: rtl/mig_line_cell.sv
module mig_line_cell
    import mig_pkg::*;
#(
    parameter int NUM_PROCS = 4,
    parameter int DET_TH    = 2,
    parameter int REV_TH    = 2,
    parameter int PROC_W    = $clog2(NUM_PROCS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit_req,
    input  logic [1:0]        req_kind,
    input  logic [PROC_W-1:0] req_proc,
    input  logic              hit_rev,
    output logic              convert
);

    localparam int DW = $clog2(DET_TH + 1);
    localparam int RW = $clog2(REV_TH + 1);
    localparam logic [NUM_PROCS-1:0] ONE = NUM_PROCS'(1);
    localparam logic [DW-1:0] DET_LAST = DW'(DET_TH - 1);
    localparam logic [DW-1:0] DET_FULL = DW'(DET_TH);
    localparam logic [RW-1:0] REV_LAST = RW'(REV_TH - 1);
    localparam logic [RW-1:0] REV_FULL = RW'(REV_TH);

    line_state_e            st_q, st_d;
    logic [DW-1:0]          det_q, det_d;
    logic [RW-1:0]          rev_q, rev_d;
    logic [NUM_PROCS-1:0]   shr_q, shr_d;
    logic [PROC_W-1:0]      own_q, own_d;
    logic                   own_vld_q, own_vld_d;
    logic                   is_read, is_excl, sole, mig_evt;

    // request classification
    always_comb begin
        is_read = (req_kind == REQ_RD);
        is_excl = (req_kind == REQ_RDX) || (req_kind == REQ_UPG);
        sole    = (shr_q == (ONE << req_proc));
        mig_evt = hit_req && is_excl && sole && own_vld_q && (own_q != req_proc);
        convert = hit_req && is_read && (st_q == LS_MIGR) && !hit_rev;
    end

    // per-line state machine: next state and counters
    always_comb begin
        st_d  = st_q;
        det_d = det_q;
        rev_d = rev_q;
        unique case (st_q)
            LS_TRACK: begin
                if (mig_evt) begin
                    if (det_q == DET_LAST) begin
                        det_d = DET_FULL;
                        st_d  = LS_MIGR;
                    end else begin
                        det_d = det_q + 1'b1;
                    end
                end
            end
            LS_MIGR: begin
                if (hit_rev) begin
                    det_d = '0;
                    if (rev_q == REV_LAST) begin
                        rev_d = REV_FULL;
                        st_d  = LS_PINNED;
                    end else begin
                        rev_d = rev_q + 1'b1;
                        st_d  = LS_TRACK;
                    end
                end
            end
            LS_PINNED: begin
                st_d = LS_PINNED;
            end
            default: begin
                st_d = LS_TRACK;
            end
        endcase
    end

    // reader set and owner bookkeeping
    always_comb begin
        shr_d     = shr_q;
        own_d     = own_q;
        own_vld_d = own_vld_q;
        if (hit_req) begin
            if (is_read && !convert) begin
                shr_d = shr_q | (ONE << req_proc);
            end else if (is_excl || convert) begin
                shr_d     = '0;
                own_d     = req_proc;
                own_vld_d = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= LS_TRACK;
            det_q     <= '0;
            rev_q     <= '0;
            shr_q     <= '0;
            own_q     <= '0;
            own_vld_q <= 1'b0;
        end else begin
            st_q      <= st_d;
            det_q     <= det_d;
            rev_q     <= rev_d;
            shr_q     <= shr_d;
            own_q     <= own_d;
            own_vld_q <= own_vld_d;
        end
    end

    AST_PINNED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == LS_PINNED |=> st_q == LS_PINNED); // R8

    AST_REVERT_LEAVES_MIGR: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LS_MIGR) && hit_rev |=> (st_q != LS_MIGR) && (det_q == '0)); // R6

    AST_TRACK_REVERT_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LS_TRACK) && hit_rev && !mig_evt |=> (st_q == LS_TRACK) && $stable(det_q) && $stable(rev_q)); // R7

    AST_DET_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        det_q <= DET_FULL); // R3

    AST_REV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rev_q <= REV_FULL); // R8

endmodule

// File: rtl/mig_detector.sv
module mig_detector
    import mig_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int NUM_PROCS = 4,
    parameter int DET_TH    = 2,
    parameter int REV_TH    = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic [1:0]                    req_kind,
    input  logic [$clog2(NUM_PROCS)-1:0]  req_proc,
    input  logic [$clog2(NUM_LINES)-1:0]  req_line,
    input  logic                          rev_valid,
    input  logic [$clog2(NUM_LINES)-1:0]  rev_line,
    output logic                          grant_valid,
    output logic [1:0]                    grant_kind,
    output logic                          grant_migr
);

    localparam int LINE_W = $clog2(NUM_LINES);
    localparam int PROC_W = $clog2(NUM_PROCS);

    logic [NUM_LINES-1:0] conv_vec;
    logic                 any_conv;
    logic                 nxt_valid, nxt_migr;
    logic [1:0]           nxt_kind;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        mig_line_cell #(
            .NUM_PROCS (NUM_PROCS),
            .DET_TH    (DET_TH),
            .REV_TH    (REV_TH),
            .PROC_W    (PROC_W)
        ) i_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .hit_req  (req_valid && (req_line == LINE_W'(g))),
            .req_kind (req_kind),
            .req_proc (req_proc),
            .hit_rev  (rev_valid && (rev_line == LINE_W'(g))),
            .convert  (conv_vec[g])
        );
    end

    // output decision
    always_comb begin
        any_conv  = |conv_vec;
        nxt_valid = req_valid;
        nxt_migr  = any_conv;
        nxt_kind  = '0;
        if (req_valid) begin
            nxt_kind = any_conv ? REQ_RDX : req_kind;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_valid <= 1'b0;
            grant_kind  <= '0;
            grant_migr  <= 1'b0;
        end else begin
            grant_valid <= nxt_valid;
            grant_kind  <= nxt_kind;
            grant_migr  <= nxt_migr;
        end
    end

    AST_MIGR_IS_RDX: assert property (@(posedge clk) disable iff (!rst_n)
        grant_migr |-> grant_valid && (grant_kind == REQ_RDX)); // R4

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> grant_valid); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !grant_valid && !grant_migr); // R2

    AST_NONREAD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (req_kind != REQ_RD) |=> (grant_kind == $past(req_kind)) && !grant_migr); // R5

    AST_SINGLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(conv_vec)); // R9

endmodule

// File: tb/test_mig_detector.sv
`timescale 1ns/1ps
module test_mig_detector;

    typedef struct packed {
        logic       rq;
        logic [3:0] ln;
        logic [1:0] pr;
        logic [1:0] ty;
        logic       rv;
        logic [3:0] rl;
        logic [1:0] et;
        logic       em;
    } vec_t;

    localparam logic [1:0] RD = 2'd0, RX = 2'd1, UP = 2'd2, RS = 2'd3;
    localparam logic [3:0] L0 = 4'd0, L3 = 4'd3, L5 = 4'd5, L9 = 4'd9;
    localparam int NV = 27;

    // R3 R4 R5 R6 R7 R8 R9 R10 exercised along this table
    localparam vec_t VECS [NV] = '{
        '{1'b1, L3, 2'd0, RX, 1'b0, L0, RX, 1'b0},
        '{1'b1, L3, 2'd1, RD, 1'b0, L0, RD, 1'b0},
        '{1'b1, L3, 2'd1, UP, 1'b0, L0, UP, 1'b0},
        '{1'b1, L3, 2'd2, RD, 1'b0, L0, RD, 1'b0},
        '{1'b1, L3, 2'd2, RX, 1'b0, L0, RX, 1'b0},
        '{1'b1, L3, 2'd3, RD, 1'b0, L0, RX, 1'b1},
        '{1'b1, L3, 2'd0, UP, 1'b0, L0, UP, 1'b0},
        '{1'b1, L5, 2'd1, RD, 1'b0, L0, RD, 1'b0},
        '{1'b0, L0, 2'd0, RD, 1'b1, L5, RD, 1'b0},
        '{1'b0, L0, 2'd0, RD, 1'b1, L3, RD, 1'b0},
        '{1'b1, L3, 2'd1, RD, 1'b0, L0, RD, 1'b0},
        '{1'b1, L3, 2'd1, RX, 1'b0, L0, RX, 1'b0},
        '{1'b1, L3, 2'd2, RD, 1'b0, L0, RD, 1'b0},
        '{1'b1, L3, 2'd3, RD, 1'b0, L0, RD, 1'b0},
        '{1'b1, L3, 2'd3, RX, 1'b0, L0, RX, 1'b0},
        '{1'b1, L3, 2'd3, RD, 1'b0, L0, RD, 1'b0},
        '{1'b1, L3, 2'd3, UP, 1'b0, L0, UP, 1'b0},
        '{1'b1, L3, 2'd0, RD, 1'b0, L0, RD, 1'b0},
        '{1'b1, L3, 2'd0, RX, 1'b0, L0, RX, 1'b0},
        '{1'b1, L3, 2'd1, RD, 1'b1, L3, RD, 1'b0},
        '{1'b1, L3, 2'd1, UP, 1'b0, L0, UP, 1'b0},
        '{1'b1, L3, 2'd2, RD, 1'b0, L0, RD, 1'b0},
        '{1'b1, L3, 2'd2, RX, 1'b0, L0, RX, 1'b0},
        '{1'b1, L3, 2'd3, RD, 1'b0, L0, RD, 1'b0},
        '{1'b1, L9, 2'd0, RS, 1'b0, L0, RS, 1'b0},
        '{1'b0, L0, 2'd0, RD, 1'b1, L3, RD, 1'b0},
        '{1'b1, L3, 2'd0, RD, 1'b0, L0, RD, 1'b0}
    };

    localparam string TAGS [NV] = '{
        "R2", "R2", "R3", "R2", "R3", "R4", "R5", "R9", "R7",
        "R6", "R6", "R6", "R3", "R3", "R3", "R3", "R3", "R3",
        "R3", "R10", "R8", "R8", "R8", "R8", "R2", "R7", "R8"
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_kind = 2'd0;
    logic [1:0] req_proc = 2'd0;
    logic [3:0] req_line = 4'd0;
    logic       rev_valid = 1'b0;
    logic [3:0] rev_line = 4'd0;
    logic       grant_valid;
    logic [1:0] grant_kind;
    logic       grant_migr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mig_detector #(
        .NUM_LINES (16),
        .NUM_PROCS (4),
        .DET_TH    (2),
        .REV_TH    (2)
    ) i_mig_detector (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_kind    (req_kind),
        .req_proc    (req_proc),
        .req_line    (req_line),
        .rev_valid   (rev_valid),
        .rev_line    (rev_line),
        .grant_valid (grant_valid),
        .grant_kind  (grant_kind),
        .grant_migr  (grant_migr)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v, input string tag);
        @(negedge clk);
        req_valid = v.rq;
        req_line  = v.ln;
        req_proc  = v.pr;
        req_kind  = v.ty;
        rev_valid = v.rv;
        rev_line  = v.rl;
        @(posedge clk);
        #1;
        check(grant_valid == v.rq, tag, "grant_valid", int'(grant_valid), int'(v.rq));
        if (v.rq) begin
            check(grant_kind == v.et, tag, "grant_kind", int'(grant_kind), int'(v.et));
            check(grant_migr == v.em, tag, "grant_migr", int'(grant_migr), int'(v.em));
        end else begin
            check(grant_migr == 1'b0, tag, "grant_migr idle", int'(grant_migr), 0);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        rev_valid = 1'b0;
        @(posedge clk);
        #1;
        check(grant_valid == 1'b0, "R1", "reset grant_valid", int'(grant_valid), 0);
        check(grant_kind == 2'd0, "R1", "reset grant_kind", int'(grant_kind), 0);
        check(grant_migr == 1'b0, "R1", "reset grant_migr", int'(grant_migr), 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        do_reset();

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i], TAGS[i]);
        end

        // R1: reset clears the pin on line 3; detection works again
        do_reset();
        apply('{1'b1, L3, 2'd0, RX, 1'b0, L0, RX, 1'b0}, "R1");
        apply('{1'b1, L3, 2'd1, RD, 1'b0, L0, RD, 1'b0}, "R1");
        apply('{1'b1, L3, 2'd1, UP, 1'b0, L0, UP, 1'b0}, "R1");
        apply('{1'b1, L3, 2'd2, RD, 1'b0, L0, RD, 1'b0}, "R1");
        apply('{1'b1, L3, 2'd2, RX, 1'b0, L0, RX, 1'b0}, "R1");
        apply('{1'b1, L3, 2'd3, RD, 1'b0, L0, RX, 1'b1}, "R1");
        // R2: idle cycle after a grant
        apply('{1'b0, L0, 2'd0, RD, 1'b0, L0, RD, 1'b0}, "R2");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule